// File: doc/BRIEF.md
# Lane Deskew Elastic Buffer with Fixed-Phase Release

This block sits behind the receive lanes of a multi-lane serial converter link, where every lane delivers four octets per clock in a common device-clock domain. Lanes reach this point with different delays. Each lane marks the first word of its own multiframes. The block buffers each lane in a small FIFO and reads all FIFOs out together. Because the read-out starts at a fixed point of a local multiframe counter, the end-to-end latency is the same after every reset, however the lane skew happens to fall.

The local multiframe counter runs with a period set by the programmed frames-per-multiframe and octets-per-frame values. A rising edge on the SYSREF input, sampled in the device clock, sets its phase. After that first edge, each lane starts filling its FIFO at its next multiframe marker. Once every lane has started, the block waits for the next counter wrap, then a programmable number of extra cycles, and then starts the common read-out. From that point a data-valid output runs continuously.

Buffer faults are flagged per lane and drop data-valid for good. These are writes into a full FIFO, reads from an empty one, and skew too large to be covered before release. Late SYSREF edges that fall off the established phase are flagged but do not move the counter. The fill level of each FIFO at release is kept for skew diagnosis.

Top module: `lane_deskew_buffer`

## Requirements
- R1: The multiframe counter has a period of (cfg_k × cfg_f) / 4 cycles. The first sampled SYSREF rising edge (sampled high after a sampled low) restarts it at zero on that clock edge.
- R2: A lane multiframe marker is ignored until the first SYSREF edge has phased the counter; only a marker after that starts the lane's FIFO, and the marked word is the first one stored.
- R3: The common read-out begins (cfg_rel_ofs + 1) cycles after the first counter wrap that follows the start of all lanes. out_valid first rises one cycle after that, so its distance from SYSREF does not depend on the lane skew.
- R4: out_data carries lane n in bits [32n+31:32n]. Every valid output word holds, on each lane, that lane's k-th stored word, where k is the number of earlier valid output words.
- R5: out_valid is low until release and then stays high on every cycle until an overflow, underflow or misalignment flag is set, after which it stays low.
- R6: rel_fill bits [6n+5:6n] hold lane n's FIFO occupancy in the cycle of the first read. This equals the number of words the lane stored from its marker up to and including that cycle.
- R7: A write to a full lane FIFO (32 entries, no read in the same cycle) is dropped and sets that lane's bit in ovf_flag, which stays set until reset.
- R8: A read from an empty lane FIFO sets that lane's bit in udf_flag, which stays set until reset, and the word read is not marked valid.
- R9: If any lane FIFO holds 32 entries before release, misalignment is set and stays set until reset, and no release takes place.
- R10: After phasing, a SYSREF edge whose clock edge is not a counter wrap sets sysref_phase_err (sticky) and does not reload the counter. An edge on a wrap sets nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock, datapath of four octets per lane per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sysref | input | 1 | Multiframe phase reference, sampled on the rising clock edge |
| cfg_k | input | 8 | Frames per multiframe |
| cfg_f | input | 4 | Octets per frame per lane |
| cfg_rel_ofs | input | 8 | Extra cycles between the release wrap and the first read |
| lane_data | input | 128 | Lane words, lane n in bits [32n+31:32n] |
| lane_valid | input | 4 | Per-lane word valid |
| lane_mfs | input | 4 | Per-lane multiframe start marker |
| out_data | output | 128 | Aligned lane words, same packing as lane_data |
| out_valid | output | 1 | Aligned output data valid |
| rel_fill | output | 24 | Per-lane FIFO fill at release, 6 bits per lane |
| ovf_flag | output | 4 | Sticky per-lane overflow |
| udf_flag | output | 4 | Sticky per-lane underflow |
| misalign | output | 1 | Sticky skew-beyond-capacity flag |
| sysref_phase_err | output | 1 | Sticky off-phase SYSREF flag |

## Verification
The bench keeps the default four lanes of 32 bits and 32-entry FIFOs. It drives two framings, K=8/F=4 with an 8-cycle multiframe and K=4/F=4 with a 4-cycle one, so the change in release wrap with the period can be seen. With release offsets of 2 and 5 and two different skew patterns, it shows that first-valid latency follows the offset and the period but not the skew, and that the fill levels track each lane's arrival. With four lanes, a single lane can be stalled to drain it into underflow, or left without a marker so the others fill their 32 entries into misalignment and overflow. A second SYSREF placed on and off the wrap tests the phase-error rule.

// File: rtl/ldb_pkg.sv
package ldb_pkg;
  typedef enum logic [1:0] {
    RS_WAIT  = 2'd0,
    RS_DELAY = 2'd1,
    RS_RUN   = 2'd2
  } rel_state_e;
endpackage

// File: rtl/lmfc_phaser.sv
// Local multiframe counter. The period comes from the framing values.
// The phase is taken from the first SYSREF rising edge.
module lmfc_phaser #(
  parameter int K_W = 8,
  parameter int F_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sysref,
  input  logic [K_W-1:0] cfg_k,
  input  logic [F_W-1:0] cfg_f,
  output logic           wrap,
  output logic           phased,
  output logic           phase_err
);
  localparam int PROD_W = K_W + F_W;
  localparam int CNT_W  = PROD_W - 2;

  logic [PROD_W-1:0] prod;
  logic [CNT_W-1:0]  len;
  logic [CNT_W-1:0]  last;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              sref_q;
  logic              phased_d;
  logic              perr_d;
  logic              sref_edge;

  always_comb begin
    prod      = {{F_W{1'b0}}, cfg_k} * {{K_W{1'b0}}, cfg_f};
    len       = prod[PROD_W-1:2];
    last      = (len == '0) ? '0 : len - 1'b1;
    wrap      = (cnt_q >= last);
    sref_edge = sysref & ~sref_q;
  end

  always_comb begin
    cnt_d    = cnt_q;
    phased_d = phased;
    perr_d   = phase_err;
    if (sref_edge && !phased) begin
      cnt_d    = '0;
      phased_d = 1'b1;
    end else if (wrap) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
    if (sref_edge && phased && !wrap) begin
      perr_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      sref_q    <= 1'b0;
      phased    <= 1'b0;
      phase_err <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      sref_q    <= sysref;
      phased    <= phased_d;
      phase_err <= perr_d;
    end
  end
endmodule

// File: rtl/lane_fifo.sv
// Per-lane elastic FIFO. Writing starts at the first marker after phasing.
// Overflow and underflow flags are sticky.
module lane_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       phased,
  input  logic                       mfs,
  input  logic                       valid,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       rd_en,
  output logic [DATA_W-1:0]          head,
  output logic [$clog2(DEPTH):0]     level,
  output logic                       started,
  output logic                       full,
  output logic                       ovf_flag,
  output logic                       udf_flag,
  output logic                       err_set
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int LVL_W = PTR_W + 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, wr_ptr_d;
  logic [PTR_W-1:0]  rd_ptr, rd_ptr_d;
  logic [LVL_W-1:0]  level_d;
  logic              started_d;
  logic              wr_req, wr_do, rd_do, empty;
  logic              ovf_set, udf_set;

  always_comb begin
    full      = (level == LVL_FULL);
    empty     = (level == '0);
    started_d = started | (phased & mfs);
    wr_req    = started_d & valid;
    rd_do     = rd_en & ~empty;
    wr_do     = wr_req & (~full | rd_do);
    ovf_set   = wr_req & ~wr_do;
    udf_set   = rd_en & empty;
    err_set   = ovf_set | udf_set;
    head      = mem[rd_ptr];
  end

  always_comb begin
    wr_ptr_d = wr_ptr;
    rd_ptr_d = rd_ptr;
    level_d  = level;
    if (wr_do) begin
      wr_ptr_d = (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
    end
    if (rd_do) begin
      rd_ptr_d = (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
    end
    case ({wr_do, rd_do})
      2'b10:   level_d = level + 1'b1;
      2'b01:   level_d = level - 1'b1;
      default: level_d = level;
    endcase
  end

  always_ff @(posedge clk) begin
    if (wr_do) begin
      mem[wr_ptr] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      level    <= '0;
      started  <= 1'b0;
      ovf_flag <= 1'b0;
      udf_flag <= 1'b0;
    end else begin
      wr_ptr   <= wr_ptr_d;
      rd_ptr   <= rd_ptr_d;
      level    <= level_d;
      started  <= started_d;
      ovf_flag <= ovf_flag | ovf_set;
      udf_flag <= udf_flag | udf_set;
    end
  end
endmodule

// File: rtl/release_ctrl.sv
// Waits for all lanes, then for a counter wrap, then for the offset,
// and then reads all lanes on every cycle.
module release_ctrl
  import ldb_pkg::*;
#(
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrap,
  input  logic             all_started,
  input  logic             halt,
  input  logic [OFS_W-1:0] cfg_ofs,
  output logic             rd_en,
  output logic             first_rd,
  output logic             released
);
  rel_state_e       state_q, state_d;
  logic [OFS_W-1:0] ofs_q, ofs_d;

  always_comb begin
    state_d  = state_q;
    ofs_d    = ofs_q;
    rd_en    = 1'b0;
    first_rd = 1'b0;
    case (state_q)
      RS_WAIT: begin
        if (all_started && wrap && !halt) begin
          state_d = RS_DELAY;
          ofs_d   = cfg_ofs;
        end
      end
      RS_DELAY: begin
        if (ofs_q == '0) begin
          rd_en    = 1'b1;
          first_rd = 1'b1;
          state_d  = RS_RUN;
        end else begin
          ofs_d = ofs_q - 1'b1;
        end
      end
      RS_RUN: begin
        rd_en = 1'b1;
      end
      default: state_d = RS_WAIT;
    endcase
    released = (state_q == RS_RUN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RS_WAIT;
      ofs_q   <= '0;
    end else begin
      state_q <= state_d;
      ofs_q   <= ofs_d;
    end
  end
endmodule

// File: rtl/lane_deskew_buffer.sv
module lane_deskew_buffer #(
  parameter int NUM_LANES = 4,
  parameter int LANE_W    = 32,
  parameter int DEPTH     = 32,
  parameter int K_W       = 8,
  parameter int F_W       = 4,
  parameter int OFS_W     = 8,
  localparam int FILL_W   = $clog2(DEPTH) + 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sysref,
  input  logic [K_W-1:0]                cfg_k,
  input  logic [F_W-1:0]                cfg_f,
  input  logic [OFS_W-1:0]              cfg_rel_ofs,
  input  logic [NUM_LANES*LANE_W-1:0]   lane_data,
  input  logic [NUM_LANES-1:0]          lane_valid,
  input  logic [NUM_LANES-1:0]          lane_mfs,
  output logic [NUM_LANES*LANE_W-1:0]   out_data,
  output logic                          out_valid,
  output logic [NUM_LANES*FILL_W-1:0]   rel_fill,
  output logic [NUM_LANES-1:0]          ovf_flag,
  output logic [NUM_LANES-1:0]          udf_flag,
  output logic                          misalign,
  output logic                          sysref_phase_err
);
  logic                        wrap, phased;
  logic                        rd_en, first_rd, released;
  logic [NUM_LANES-1:0]        started_v, full_v, err_set_v;
  logic [NUM_LANES*LANE_W-1:0] head_v;
  logic [NUM_LANES*FILL_W-1:0] level_v;
  logic                        any_err, mis_set, err_set;
  logic                        out_valid_d;
  logic [NUM_LANES*LANE_W-1:0] out_data_d;
  logic [NUM_LANES*FILL_W-1:0] rel_fill_d;

  lmfc_phaser #(.K_W(K_W), .F_W(F_W)) u_lmfc (
    .clk       (clk),
    .rst_n     (rst_n),
    .sysref    (sysref),
    .cfg_k     (cfg_k),
    .cfg_f     (cfg_f),
    .wrap      (wrap),
    .phased    (phased),
    .phase_err (sysref_phase_err)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    lane_fifo #(.DATA_W(LANE_W), .DEPTH(DEPTH)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .phased   (phased),
      .mfs      (lane_mfs[g]),
      .valid    (lane_valid[g]),
      .wr_data  (lane_data[g*LANE_W +: LANE_W]),
      .rd_en    (rd_en),
      .head     (head_v[g*LANE_W +: LANE_W]),
      .level    (level_v[g*FILL_W +: FILL_W]),
      .started  (started_v[g]),
      .full     (full_v[g]),
      .ovf_flag (ovf_flag[g]),
      .udf_flag (udf_flag[g]),
      .err_set  (err_set_v[g])
    );
  end

  release_ctrl #(.OFS_W(OFS_W)) u_rel (
    .clk         (clk),
    .rst_n       (rst_n),
    .wrap        (wrap),
    .all_started (&started_v),
    .halt        (any_err),
    .cfg_ofs     (cfg_rel_ofs),
    .rd_en       (rd_en),
    .first_rd    (first_rd),
    .released    (released)
  );

  always_comb begin
    any_err     = (|ovf_flag) | (|udf_flag) | misalign;
    mis_set     = ~released & (|full_v);
    err_set     = (|err_set_v) | mis_set;
    out_valid_d = rd_en & ~any_err & ~err_set;
    out_data_d  = rd_en ? head_v : out_data;
    rel_fill_d  = first_rd ? level_v : rel_fill;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data  <= '0;
      out_valid <= 1'b0;
      rel_fill  <= '0;
      misalign  <= 1'b0;
    end else begin
      out_data  <= out_data_d;
      out_valid <= out_valid_d;
      rel_fill  <= rel_fill_d;
      misalign  <= misalign | mis_set;
    end
  end
endmodule

// File: rtl/lane_deskew_buffer_checker.sv
module lane_deskew_buffer_checker #(
  parameter int NUM_LANES = 4,
  parameter int DEPTH     = 32,
  localparam int FILL_W   = $clog2(DEPTH) + 1
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        out_valid,
  input logic [NUM_LANES*FILL_W-1:0] rel_fill,
  input logic [NUM_LANES-1:0]        ovf_flag,
  input logic [NUM_LANES-1:0]        udf_flag,
  input logic                        misalign,
  input logic                        sysref_phase_err
);
  logic buf_err;
  assign buf_err = (|ovf_flag) | (|udf_flag) | misalign;

  assert_valid_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !buf_err);

  assert_valid_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> buf_err);

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag != '0) |=> (($past(ovf_flag) & ~ovf_flag) == '0));

  assert_udf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (udf_flag != '0) |=> (($past(udf_flag) & ~udf_flag) == '0));

  assert_misalign_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |=> misalign);

  assert_phase_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sysref_phase_err |=> sysref_phase_err);

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_fill
    assert_fill_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rel_fill[g*FILL_W +: FILL_W] <= FILL_W'(DEPTH));
  end
endmodule

bind lane_deskew_buffer lane_deskew_buffer_checker #(
  .NUM_LANES (NUM_LANES),
  .DEPTH     (DEPTH)
) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .out_valid        (out_valid),
  .rel_fill         (rel_fill),
  .ovf_flag         (ovf_flag),
  .udf_flag         (udf_flag),
  .misalign         (misalign),
  .sysref_phase_err (sysref_phase_err)
);

// File: tb/lane_deskew_buffer_test.sv
`timescale 1ns/1ps
module lane_deskew_buffer_test;
  localparam int NL = 4;
  localparam int LW = 32;
  localparam int FW = 6;

  logic            clk;
  logic            rst_n;
  logic            sysref;
  logic [7:0]      cfg_k;
  logic [3:0]      cfg_f;
  logic [7:0]      cfg_rel_ofs;
  logic [NL*LW-1:0] lane_data;
  logic [NL-1:0]   lane_valid;
  logic [NL-1:0]   lane_mfs;
  logic [NL*LW-1:0] out_data;
  logic            out_valid;
  logic [NL*FW-1:0] rel_fill;
  logic [NL-1:0]   ovf_flag;
  logic [NL-1:0]   udf_flag;
  logic            misalign;
  logic            sysref_phase_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit mon_en = 0;
  bit prev_v = 0;
  int sb[$];

  lane_deskew_buffer uut (
    .clk(clk), .rst_n(rst_n), .sysref(sysref), .cfg_k(cfg_k), .cfg_f(cfg_f),
    .cfg_rel_ofs(cfg_rel_ofs), .lane_data(lane_data), .lane_valid(lane_valid),
    .lane_mfs(lane_mfs), .out_data(out_data), .out_valid(out_valid),
    .rel_fill(rel_fill), .ovf_flag(ovf_flag), .udf_flag(udf_flag),
    .misalign(misalign), .sysref_phase_err(sysref_phase_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every valid output word (R4, R5)
  always @(negedge clk) begin
    if (mon_en && rst_n) begin
      if (out_valid) begin
        checks++;
        if (sb.size() == 0) begin
          fails++;
          $display("FAIL R4 valid word with empty scoreboard: actual 1 expected 0");
        end else begin
          int e;
          e = sb.pop_front();
          for (int l = 0; l < NL; l++) begin
            if (out_data[l*LW +: LW] != {8'(l), 24'(e)}) begin
              fails++;
              $display("FAIL R4 lane %0d word: actual %h expected %h",
                       l, out_data[l*LW +: LW], {8'(l), 24'(e)});
            end
          end
        end
      end
      if (prev_v && !out_valid) begin
        checks++;
        if (!((|ovf_flag) || (|udf_flag) || misalign)) begin
          fails++;
          $display("FAIL R5 valid dropped without error: actual 0 expected 1");
        end
      end
      prev_v = out_valid;
    end else begin
      prev_v = 1'b0;
    end
  end

  task automatic do_reset();
    rst_n = 1'b0; sysref = 1'b0; lane_mfs = '0; lane_valid = '0; lane_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5", out_valid, 0, "out_valid after reset");
    chk("R7", ovf_flag, 0, "ovf after reset");
    chk("R8", udf_flag, 0, "udf after reset");
    chk("R9", misalign, 0, "misalign after reset");
    chk("R10", sysref_phase_err, 0, "phase err after reset");
  endtask

  // scen: 0 plain/underflow, 1 phase tests, 2 misalignment
  task automatic run_case(input int kk, input int ff, input int ofs,
                          input int m0, input int m1, input int m2, input int m3,
                          input int stall_lane, input int scen, input int exp_lat,
                          input int f0, input int f1, input int f2, input int f3);
    int m[4];
    int ef[4];
    int seq[4];
    int first_t;
    m = '{m0, m1, m2, m3};
    ef = '{f0, f1, f2, f3};
    seq = '{0, 0, 0, 0};
    first_t = -1;
    mon_en = 0;
    sb.delete();
    cfg_k = 8'(kk); cfg_f = 4'(ff); cfg_rel_ofs = 8'(ofs);
    do_reset();
    // R2: markers before SYSREF must be ignored
    lane_valid = '1;
    lane_data = {NL{32'hEE00_0000}};
    lane_mfs = '1;
    @(negedge clk);
    lane_mfs = '0;
    repeat (2) @(negedge clk);
    mon_en = 1;
    for (int t = 0; t < 120; t++) begin
      @(negedge clk);
      sysref = (t == 0) || (scen == 1 && (t == 64 || t == 67));
      for (int l = 0; l < NL; l++) begin
        bit vl;
        vl = !(l == stall_lane && t >= 50 && t < 70);
        lane_mfs[l] = (t == m[l]);
        lane_valid[l] = vl;
        lane_data[l*LW +: LW] = (t >= m[l]) ? {8'(l), 24'(seq[l])} : 32'hEE00_0000;
        if (vl && t >= m[l]) begin
          if (l == 0) sb.push_back(seq[0]);
          seq[l]++;
        end
      end
      if (first_t < 0 && out_valid) first_t = t;
      if (scen == 1 && t == 66) chk("R10", sysref_phase_err, 0, "SYSREF on wrap");
      if (scen == 1 && t == 70) begin
        chk("R10", sysref_phase_err, 1, "SYSREF off wrap");
        chk("R10", out_valid, 1, "valid kept after off-phase SYSREF");
      end
      if (scen == 2 && t == 30) chk("R9", misalign, 0, "misalign before capacity");
      if (scen == 2 && t == 60) begin
        chk("R9", misalign, 1, "misalign after capacity");
        chk("R7", ovf_flag, 4'b0111, "overflow on started lanes");
        chk("R9", out_valid, 0, "no release when misaligned");
      end
      if (stall_lane >= 0 && t == 80) begin
        chk("R8", udf_flag, 1 << stall_lane, "underflow on stalled lane");
        chk("R8", out_valid, 0, "valid low after underflow");
        chk("R7", ovf_flag, 0, "no overflow during stall");
      end
    end
    lane_valid = '0;
    sysref = 1'b0;
    if (exp_lat >= 0) begin
      chk("R3", first_t, exp_lat, "first valid after SYSREF");
      for (int l = 0; l < NL; l++)
        chk("R6", rel_fill[l*FW +: FW], ef[l], $sformatf("fill lane %0d", l));
    end
    mon_en = 0;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; sysref = 1'b0; cfg_k = 8'd8; cfg_f = 4'd4; cfg_rel_ofs = '0;
    lane_data = '0; lane_valid = '0; lane_mfs = '0;
    // R1 R3 R6 R8: 8-cycle multiframe, skew 3 per lane, offset 2, lane 2 stalled later
    run_case(8, 4, 2, 10, 13, 16, 19, 2, 0, 28, 17, 14, 11, 8);
    // R3 R10: different skew, same latency; SYSREF on and off the wrap
    run_case(8, 4, 2, 12, 13, 17, 20, -1, 1, 28, 15, 14, 10, 7);
    // R3: offset 5
    run_case(8, 4, 5, 10, 13, 16, 19, -1, 0, 31, 20, 17, 14, 11);
    // R1: 4-cycle multiframe
    run_case(4, 4, 0, 10, 11, 12, 13, -1, 0, 18, 7, 6, 5, 4);
    // R9 R7: lane 3 never marks
    run_case(8, 4, 0, 10, 10, 10, 1000, -1, 2, -1, 0, 0, 0, 0);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule